// File: doc/BRIEF.md
# Execute Group Redirect Selector

This block looks at the group of instructions that the issue logic hands to execute in one cycle. It walks the slots in order and decides which of them are taken into execution this cycle. Walking stops at the first empty slot, at the last slot, or once every function unit is in use. A slot that was squashed earlier is still taken, so that it is marked executed and reaches commit, but it uses no function unit.

From the slots it takes, the block picks at most one fetch redirect for the whole group: the earliest slot, in slot order, that either mispredicted its branch or, if it did not mispredict, saw the memory-order violation flag from the load/store queue. It registers a squash packet for that redirect, and the packet is valid for one cycle. Two event counters keep running totals of wrong predicted-taken branches and of memory-order redirects.

Top module: `ers_exec_redirect`

## Requirements
- R1: A slot is taken when every earlier slot was taken, the slot's valid bit is set, and fewer than EXEC_W non-squashed slots come before it. The taken set appears on `done_mask_o` one cycle after the group is presented, with bit i for slot i. Taken slots always form a run starting at slot 0.
- R2: `fu_used_o` reports how many taken slots are not squashed, one cycle later. It never exceeds EXEC_W, and once it reaches EXEC_W no further slot is taken, squashed or not.
- R3: A squashed slot that is taken appears in `done_mask_o` but adds nothing to `fu_used_o` and never produces a redirect.
- R4: Only the first redirect candidate in slot order is reported. Mispredicts and violations in later slots of the same group do not change the packet.
- R5: For a branch redirect, the packet carries the slot's sequence number, its PC in `rdr_pc_o` and its next PC in `rdr_npc_o`, with `rdr_mispred_o` = 1.
- R6: For a branch redirect, `rdr_taken_o` is 1 exactly when the next PC differs from PC + 4.
- R7: When a slot mispredicts while the violation flag is high, the redirect is a branch redirect for that slot.
- R8: A memory redirect carries the slot's sequence number and next PC, with `rdr_mispred_o` = 0, `rdr_taken_o` = 0 and `rdr_pc_o` = 0.
- R9: `rdr_vld_o` is 1 in the cycle after a group that holds a redirect candidate and 0 otherwise. When it is 0, every packet field is 0.
- R10: `cnt_pt_wrong_o` increments by one for each branch redirect whose slot was predicted taken. `cnt_memv_o` increments by one for each memory redirect. Neither changes in any other case.
- R11: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_vld_i | input | ISSUE_W | Slot holds an instruction |
| slot_sq_i | input | ISSUE_W | Slot instruction already squashed |
| slot_mis_i | input | ISSUE_W | Slot branch resolved as mispredicted |
| slot_pt_i | input | ISSUE_W | Slot branch was predicted taken |
| slot_seq_i | input | ISSUE_W*SEQ_W | Sequence numbers, slot i at bits [i*SEQ_W +: SEQ_W] |
| slot_pc_i | input | ISSUE_W*PC_W | PCs, slot i at bits [i*PC_W +: PC_W] |
| slot_npc_i | input | ISSUE_W*PC_W | Resolved next PCs, same packing |
| lsq_viol_i | input | 1 | Memory-order violation seen this cycle |
| done_mask_o | output | ISSUE_W | Slots taken into execution |
| fu_used_o | output | $clog2(EXEC_W+1) | Function units consumed |
| rdr_vld_o | output | 1 | Squash packet valid |
| rdr_seq_o | output | SEQ_W | Sequence number of the redirecting slot |
| rdr_pc_o | output | PC_W | Mispredicted PC (0 for memory redirect) |
| rdr_npc_o | output | PC_W | Redirect target |
| rdr_mispred_o | output | 1 | Redirect is a branch mispredict |
| rdr_taken_o | output | 1 | Corrected direction is taken |
| cnt_pt_wrong_o | output | CNT_W | Wrong predicted-taken branch count |
| cnt_memv_o | output | CNT_W | Memory-order redirect count |

## Verification
Directed groups cover the cases that separate the stop rules: a hole in the valid bits, a full group with no squashed slot, and a group whose squashed slots fall before and after the point where the function units run out. These show whether walking stops on an empty slot, on the function-unit limit, or on the issue width. Groups with mispredicts in two slots, a mispredict together with the violation flag, a violation alone, and a violation behind a squashed slot show which candidate wins and which packet shape goes with each kind. Random groups, compared cycle by cycle against a behavioural model, add mixes of the taken-bit polarity and of the counter increments.

// File: rtl/ers_pkg.sv
package ers_pkg;
    // Kind of redirect chosen for a group
    typedef enum logic {
        RD_BRANCH = 1'b0,
        RD_MEMORY = 1'b1
    } rd_kind_e;
endpackage

// File: rtl/ers_slot_scan.sv
module ers_slot_scan
    import ers_pkg::*;
#(
    parameter int ISSUE_W = 4,
    parameter int EXEC_W  = 2,
    localparam int FU_CW  = $clog2(EXEC_W + 1),
    localparam int IDX_W  = (ISSUE_W > 1) ? $clog2(ISSUE_W) : 1
) (
    input  logic [ISSUE_W-1:0] vld_i,
    input  logic [ISSUE_W-1:0] sq_i,
    input  logic [ISSUE_W-1:0] mis_i,
    input  logic               viol_i,
    output logic [ISSUE_W-1:0] mask_o,
    output logic [FU_CW-1:0]   fu_o,
    output logic               hit_o,
    output rd_kind_e           kind_o,
    output logic [IDX_W-1:0]   idx_o
);
    int unsigned used;
    logic        halted;

    always_comb begin
        mask_o = '0;
        hit_o  = 1'b0;
        kind_o = RD_BRANCH;
        idx_o  = '0;
        used   = 0;
        halted = 1'b0;
        for (int i = 0; i < ISSUE_W; i++) begin
            if (!halted) begin
                if (!vld_i[i] || used >= EXEC_W) begin
                    halted = 1'b1;
                end else begin
                    mask_o[i] = 1'b1;
                    if (!sq_i[i]) begin
                        used = used + 1;
                        if (!hit_o && mis_i[i]) begin
                            hit_o  = 1'b1;
                            kind_o = RD_BRANCH;
                            idx_o  = IDX_W'(i);
                        end else if (!hit_o && viol_i) begin
                            hit_o  = 1'b1;
                            kind_o = RD_MEMORY;
                            idx_o  = IDX_W'(i);
                        end
                    end
                end
            end
        end
        fu_o = FU_CW'(used);
    end
endmodule

// File: rtl/ers_evt_cnt.sv
module ers_evt_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + W'(1)));
endmodule

// File: rtl/ers_exec_redirect.sv
module ers_exec_redirect
    import ers_pkg::*;
#(
    parameter int ISSUE_W    = 4,
    parameter int EXEC_W     = 2,
    parameter int SEQ_W      = 16,
    parameter int PC_W       = 32,
    parameter int CNT_W      = 16,
    parameter int INSN_BYTES = 4,
    localparam int FU_CW     = $clog2(EXEC_W + 1),
    localparam int IDX_W     = (ISSUE_W > 1) ? $clog2(ISSUE_W) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ISSUE_W-1:0]      slot_vld_i,
    input  logic [ISSUE_W-1:0]      slot_sq_i,
    input  logic [ISSUE_W-1:0]      slot_mis_i,
    input  logic [ISSUE_W-1:0]      slot_pt_i,
    input  logic [ISSUE_W*SEQ_W-1:0] slot_seq_i,
    input  logic [ISSUE_W*PC_W-1:0] slot_pc_i,
    input  logic [ISSUE_W*PC_W-1:0] slot_npc_i,
    input  logic                    lsq_viol_i,
    output logic [ISSUE_W-1:0]      done_mask_o,
    output logic [FU_CW-1:0]        fu_used_o,
    output logic                    rdr_vld_o,
    output logic [SEQ_W-1:0]        rdr_seq_o,
    output logic [PC_W-1:0]         rdr_pc_o,
    output logic [PC_W-1:0]         rdr_npc_o,
    output logic                    rdr_mispred_o,
    output logic                    rdr_taken_o,
    output logic [CNT_W-1:0]        cnt_pt_wrong_o,
    output logic [CNT_W-1:0]        cnt_memv_o
);
    typedef struct packed {
        logic [ISSUE_W-1:0] mask;
        logic [FU_CW-1:0]   fu;
        logic               vld;
        logic [SEQ_W-1:0]   seq;
        logic [PC_W-1:0]    pc;
        logic [PC_W-1:0]    npc;
        logic               mispred;
        logic               taken;
    } state_t;

    state_t st_d, st_q;

    logic [ISSUE_W-1:0] scan_mask;
    logic [FU_CW-1:0]   scan_fu;
    logic               scan_hit;
    rd_kind_e           scan_kind;
    logic [IDX_W-1:0]   scan_idx;
    logic [SEQ_W-1:0]   sel_seq;
    logic [PC_W-1:0]    sel_pc, sel_npc;
    logic               sel_pt;
    logic               inc_pt_d, inc_mv_d;

    ers_slot_scan #(.ISSUE_W(ISSUE_W), .EXEC_W(EXEC_W)) u_scan (
        .vld_i  (slot_vld_i),
        .sq_i   (slot_sq_i),
        .mis_i  (slot_mis_i),
        .viol_i (lsq_viol_i),
        .mask_o (scan_mask),
        .fu_o   (scan_fu),
        .hit_o  (scan_hit),
        .kind_o (scan_kind),
        .idx_o  (scan_idx)
    );

    // Field select of the winning slot
    always_comb begin
        sel_seq = slot_seq_i[scan_idx*SEQ_W +: SEQ_W];
        sel_pc  = slot_pc_i[scan_idx*PC_W +: PC_W];
        sel_npc = slot_npc_i[scan_idx*PC_W +: PC_W];
        sel_pt  = slot_pt_i[scan_idx];
    end

    always_comb begin
        st_d      = '0;
        st_d.mask = scan_mask;
        st_d.fu   = scan_fu;
        inc_pt_d  = 1'b0;
        inc_mv_d  = 1'b0;
        if (scan_hit) begin
            st_d.vld = 1'b1;
            st_d.seq = sel_seq;
            st_d.npc = sel_npc;
            if (scan_kind == RD_BRANCH) begin
                st_d.mispred = 1'b1;
                st_d.pc      = sel_pc;
                st_d.taken   = (sel_npc != (sel_pc + PC_W'(INSN_BYTES)));
                inc_pt_d     = sel_pt;
            end else begin
                inc_mv_d     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    ers_evt_cnt #(.W(CNT_W)) u_cnt_pt (
        .clk(clk), .rst_n(rst_n), .inc_i(inc_pt_d), .cnt_o(cnt_pt_wrong_o)
    );
    ers_evt_cnt #(.W(CNT_W)) u_cnt_mv (
        .clk(clk), .rst_n(rst_n), .inc_i(inc_mv_d), .cnt_o(cnt_memv_o)
    );

    assign done_mask_o   = st_q.mask;
    assign fu_used_o     = st_q.fu;
    assign rdr_vld_o     = st_q.vld;
    assign rdr_seq_o     = st_q.seq;
    assign rdr_pc_o      = st_q.pc;
    assign rdr_npc_o     = st_q.npc;
    assign rdr_mispred_o = st_q.mispred;
    assign rdr_taken_o   = st_q.taken;

    // Taken slots form a run from slot 0
    a_r1_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_mask_o & (done_mask_o + ISSUE_W'(1))) == '0));
    a_r2_fu_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (fu_used_o <= FU_CW'(EXEC_W)));
    a_r2_fu_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(done_mask_o) >= int'(fu_used_o)));
    a_r9_needs_unit: assert property (@(posedge clk) disable iff (!rst_n)
        rdr_vld_o |-> (fu_used_o != '0));
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rdr_vld_o |-> (!rdr_mispred_o && !rdr_taken_o && rdr_seq_o == '0));
    a_r8_mem_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (rdr_vld_o && !rdr_mispred_o) |-> (!rdr_taken_o && rdr_pc_o == '0));
    a_r10_memv_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_memv_o != $past(cnt_memv_o)) |-> (rdr_vld_o && !rdr_mispred_o));
endmodule

// File: tb/ers_exec_redirect_tb.sv
module ers_exec_redirect_tb;
    localparam int IW = 4;
    localparam int EW = 2;
    localparam int SW = 16;
    localparam int PW = 32;
    localparam int CW = 16;
    localparam int FW = $clog2(EW + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [IW-1:0]    vld, sq, mis, pt;
    logic [IW*SW-1:0] seq;
    logic [IW*PW-1:0] pc, npc;
    logic             viol;

    logic [IW-1:0] done_mask;
    logic [FW-1:0] fu_used;
    logic          r_vld, r_mis, r_tk;
    logic [SW-1:0] r_seq;
    logic [PW-1:0] r_pc, r_npc;
    logic [CW-1:0] c_pt, c_mv;

    ers_exec_redirect #(.ISSUE_W(IW), .EXEC_W(EW), .SEQ_W(SW), .PC_W(PW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .slot_vld_i(vld), .slot_sq_i(sq), .slot_mis_i(mis), .slot_pt_i(pt),
        .slot_seq_i(seq), .slot_pc_i(pc), .slot_npc_i(npc), .lsq_viol_i(viol),
        .done_mask_o(done_mask), .fu_used_o(fu_used),
        .rdr_vld_o(r_vld), .rdr_seq_o(r_seq), .rdr_pc_o(r_pc), .rdr_npc_o(r_npc),
        .rdr_mispred_o(r_mis), .rdr_taken_o(r_tk),
        .cnt_pt_wrong_o(c_pt), .cnt_memv_o(c_mv)
    );

    int total = 0;
    int bad = 0;
    int exp_pt = 0;
    int exp_mv = 0;
    bit finished = 0;

    task automatic chk(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic clear();
        vld = '0; sq = '0; mis = '0; pt = '0; seq = '0; pc = '0; npc = '0; viol = 1'b0;
    endtask

    task automatic put(int i, bit s, bit m, bit p, int sn, int a, int na);
        vld[i] = 1'b1; sq[i] = s; mis[i] = m; pt[i] = p;
        seq[i*SW +: SW] = SW'(sn);
        pc[i*PW +: PW]  = PW'(a);
        npc[i*PW +: PW] = PW'(na);
    endtask

    // Behavioural reference; returns the expected values through refs
    logic [IW-1:0] e_mask;
    int            e_fu;
    bit            e_vld, e_mis, e_tk;
    longint        e_seq, e_pc, e_npc;

    task automatic model();
        int  busy = 0;
        bit  stop = 0;
        e_mask = '0; e_fu = 0; e_vld = 0; e_mis = 0; e_tk = 0;
        e_seq = 0; e_pc = 0; e_npc = 0;
        for (int i = 0; i < IW; i++) begin
            if (stop) continue;
            if (!vld[i] || busy == EW) begin stop = 1; continue; end
            e_mask[i] = 1'b1;
            if (sq[i]) continue;
            busy++;
            if (e_vld) continue;
            if (mis[i]) begin
                e_vld = 1; e_mis = 1;
                e_seq = seq[i*SW +: SW];
                e_pc  = pc[i*PW +: PW];
                e_npc = npc[i*PW +: PW];
                e_tk  = (npc[i*PW +: PW] != pc[i*PW +: PW] + 32'd4);
                if (pt[i]) exp_pt++;
            end else if (viol) begin
                e_vld = 1;
                e_seq = seq[i*SW +: SW];
                e_npc = npc[i*PW +: PW];
                exp_mv++;
            end
        end
        e_fu = busy;
    endtask

    task automatic step();
        model();
        @(posedge clk);
        #1;
        chk("R1 mask", done_mask, e_mask);
        chk("R2 fu", fu_used, e_fu);
        chk("R9 vld", r_vld, e_vld);
        chk("R5 seq", r_seq, e_seq);
        chk("R5/R8 pc", r_pc, e_pc);
        chk("R5/R8 npc", r_npc, e_npc);
        chk("R7 mispred", r_mis, e_mis);
        chk("R6 taken", r_tk, e_tk);
        chk("R10 pt_cnt", c_pt, exp_pt);
        chk("R10 mv_cnt", c_mv, exp_mv);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clear();
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        chk("R11 mask", done_mask, 0);
        chk("R11 vld", r_vld, 0);
        chk("R11 cnt", c_pt + c_mv, 0);
        rst_n = 1'b1;

        // R1: hole in valid bits stops the walk
        clear(); put(0,0,0,0,1,'h100,'h104); put(2,0,1,0,3,'h108,'h200);
        step();
        chk("R1 hole_mask", done_mask, 4'b0001);

        // R2: function units run out at slot 1
        clear(); for (int i = 0; i < IW; i++) put(i,0,0,0,10+i,'h200+4*i,'h204+4*i);
        step();
        chk("R2 full_fu", fu_used, EW);

        // R3: squashed slots take no unit; squashed mispredict no redirect
        clear(); put(0,1,1,1,20,'h300,'h400); put(1,0,0,0,21,'h304,'h308);
        put(2,1,0,0,22,'h308,'h30c); put(3,0,0,0,23,'h30c,'h310);
        step();
        chk("R3 mask", done_mask, 4'b1111);
        chk("R3 novld", r_vld, 0);

        // R4: two mispredicts, first wins; R6 not-taken correction
        clear(); put(0,0,0,0,30,'h400,'h404); put(1,0,1,1,31,'h404,'h408);
        step();
        clear(); put(0,0,1,0,40,'h500,'h504); put(1,0,1,1,41,'h504,'h600);
        step();
        chk("R4 first_seq", r_seq, 40);
        chk("R6 nt", r_tk, 0);
        // R9: next cycle with no candidate clears packet
        clear(); put(0,0,0,0,50,'h10,'h14);
        step();
        chk("R9 pulse", r_vld, 0);

        // R7: mispredict and violation same slot
        clear(); put(0,0,1,0,60,'h700,'h800); viol = 1'b1;
        step();
        chk("R7 br", r_mis, 1);
        // R8: violation alone, behind a squashed slot
        clear(); put(0,1,0,0,70,'h900,'h904); put(1,0,0,0,71,'h904,'h908); viol = 1'b1;
        step();
        chk("R8 seq", r_seq, 71);
        chk("R8 mis", r_mis, 0);

        // Random groups
        for (int n = 0; n < 400; n++) begin
            int len;
            clear();
            len = $urandom_range(0, IW);
            for (int i = 0; i < len; i++) begin
                int a;
                a = int'($urandom_range(0, 'hffff)) * 4;
                put(i, ($urandom_range(0,3) == 0), ($urandom_range(0,3) == 0),
                    $urandom_range(0,1), $urandom_range(0,'hffff), a,
                    ($urandom_range(0,1) != 0) ? a + 4 : int'($urandom_range(0,'hffff)) * 4);
            end
            viol = ($urandom_range(0,4) == 0);
            step();
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule